// File: doc/BRIEF.md
# Serial Command Byte Receiver

This block is the device-side front end of a three-wire command port on a sampling converter. A fast system clock oversamples the serial clock, the active-low select and the data line. While the port is selected, each rising serial-clock edge samples one data bit. Zeros are skipped until the first 1 arrives. That 1 is the start bit, and the next seven bits complete an 8-bit command. The block decodes the input polarity, the conversion clock source and a two-bit operation code from the command. It loads three general-purpose output bits into a port register. It also tells the downstream conversion sequencer when to abort the current operation and when start-bit detection has been re-armed.

After a command has been accepted, the receiver ignores the line until the sequencer reports completion with `op_done`. The only other way back is a deselect/reselect pulse on the select line, which re-arms detection while the operation is still running. A start bit that arrives in that re-armed window aborts the running operation and begins a new command. A power-down command first runs one conversion, which keeps the acquisition length of the previous conversion. The receiver then sleeps until the next start bit.

The control state machine has five states:
- HUNT: armed and idle.
- SHIFT: collecting the command.
- BUSY: operation running, line ignored.
- REARMED: operation running, hunting a start bit.
- SLEEP: software power-down, hunting a start bit.

Its transitions are:
- HUNT→SHIFT on a start bit.
- SHIFT→BUSY on the eighth bit.
- BUSY→HUNT on `op_done`.
- BUSY→SLEEP on `op_done` after a power-down command.
- BUSY→REARMED on a select falling edge.
- REARMED→SHIFT on a start bit, which is an abort.
- REARMED→HUNT or SLEEP on `op_done`.
- SLEEP→SHIFT on a start bit.

Top module: `ctrl_byte_rx`

## Requirements
- R1: While hunting with select low, 0 bits have no effect. The first 1 sampled on a rising serial-clock edge is the start bit, which is bit 7 of the command.
- R2: Bit 6 of the command drives `cfg_unipolar` (1 = unipolar, 0 = bipolar). Bit 5 drives `cfg_int_clk` (1 = internal conversion clock, 0 = external).
- R3: Bits 4:3 of the command drive `op_mode`:
  - 00 is a 24-clock short-acquisition conversion.
  - 01 is calibration.
  - 10 is software power-down.
  - 11 is a 32-clock long-acquisition conversion.
  `acq_long` becomes 0 after 00 and 1 after 11. Codes 01 and 10 leave it unchanged.
- R4: Bits 2:0 of the command load `port_out[2:0]`. All three bits and the decoded fields change together, in the same cycle as a one-cycle `byte_valid` pulse, and at no other time.
- R5: While `csn_pin` is high, `sclk_pin` and `din_pin` have no effect.
- R6: After a command is accepted, further bits produce no command until `op_done` is pulsed, unless re-armed as in R7.
- R7: A select high-then-low during a running operation gives one `rearm_pulse`. A start bit after that gives one `abort_pulse` and begins a new command.
- R8: While `rst_n` is low, and after it is released:
  - `port_out` is 0.
  - `cfg_unipolar` is 0.
  - `cfg_int_clk` is 1.
  - `op_mode` is 00.
  - `acq_long` is 0.
  - `powered_down` is 0.
- R9: While `shdn_n` is low, serial input is ignored and `port_out` and the configuration hold their values.
- R10: After a power-down command, `powered_down` rises once `op_done` arrives. The next start bit clears it without an `abort_pulse`, and `port_out` holds throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shdn_n | input | 1 | Active-low hardware shutdown, synchronous to clk |
| sclk_pin | input | 1 | Serial clock, asynchronous |
| csn_pin | input | 1 | Active-low select, asynchronous |
| din_pin | input | 1 | Serial data, asynchronous |
| op_done | input | 1 | One-cycle pulse from the sequencer: operation finished |
| byte_valid | output | 1 | One-cycle pulse when a command has been accepted |
| cfg_unipolar | output | 1 | Input polarity: 1 unipolar, 0 bipolar |
| cfg_int_clk | output | 1 | Conversion clock source: 1 internal, 0 external |
| op_mode | output | 2 | Operation code of the last command |
| acq_long | output | 1 | Acquisition length to use: 1 long, 0 short |
| port_out | output | 3 | General-purpose port register |
| abort_pulse | output | 1 | One-cycle pulse: abort the running operation |
| rearm_pulse | output | 1 | One-cycle pulse: start-bit detection re-armed |
| powered_down | output | 1 | Software power-down or hardware shutdown in effect |

## Verification
The assertions assume that `shdn_n` and `op_done` are already synchronous to `clk`. They also assume that `op_done` is a single-cycle pulse. Each serial-clock phase, and each data setup before a rising edge, is taken to last several system clocks, so that every serial edge yields exactly one strobe. The bench holds each level for four system clocks. It changes data only while the serial clock is low, and pulses `op_done` only when an operation is running.

// File: rtl/ctrl_rx_pkg.sv
package ctrl_rx_pkg;

    localparam int CMD_BITS  = 8;
    localparam int PAY_BITS  = CMD_BITS - 1;
    localparam int PORT_BITS = 3;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SHIFT,
        ST_BUSY,
        ST_REARMED,
        ST_SLEEP
    } rx_state_e;

    typedef enum logic [1:0] {
        OP_SHORT = 2'b00,
        OP_CAL   = 2'b01,
        OP_PDOWN = 2'b10,
        OP_LONG  = 2'b11
    } op_e;

    typedef struct packed {
        logic                 unipolar;
        logic                 int_clk;
        op_e                  op;
        logic [PORT_BITS-1:0] port;
    } cmd_t;

endpackage

// File: rtl/ctrl_rx_sync.sv
module ctrl_rx_sync #(
    parameter int                 WIDTH     = 3,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RESET_VAL;
                    else        chain[s] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RESET_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ctrl_rx_fsm.sv
module ctrl_rx_fsm
    import ctrl_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                din_s,
    input  logic                cs_fall,
    input  logic                op_done,
    output logic                byte_done,
    output logic [PAY_BITS-1:0] byte_word,
    output logic                abort_pulse,
    output logic                rearm_pulse,
    output logic                sleep_st
);

    localparam int CW = $clog2(CMD_BITS);
    localparam logic [CW-1:0] LAST = CW'(CMD_BITS - 1);

    rx_state_e           state, nxt;
    logic [CW-1:0]       cnt;
    logic [PAY_BITS-2:0] shreg;
    logic                pd_pend;
    logic                start_seen;

    assign start_seen = bit_stb && din_s;
    assign byte_done  = (state == ST_SHIFT) && bit_stb && (cnt == LAST);
    assign byte_word  = {shreg, din_s};
    assign sleep_st   = (state == ST_SLEEP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:    if (start_seen) nxt = ST_SHIFT;
            ST_SHIFT:   if (byte_done) nxt = ST_BUSY;
            ST_BUSY: begin
                if (op_done)      nxt = pd_pend ? ST_SLEEP : ST_HUNT;
                else if (cs_fall) nxt = ST_REARMED;
            end
            ST_REARMED: begin
                if (start_seen)   nxt = ST_SHIFT;
                else if (op_done) nxt = pd_pend ? ST_SLEEP : ST_HUNT;
            end
            ST_SLEEP:   if (start_seen) nxt = ST_SHIFT;
            default:    nxt = ST_HUNT;
        endcase
    end

    // datapath and output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            shreg       <= '0;
            pd_pend     <= 1'b0;
            abort_pulse <= 1'b0;
            rearm_pulse <= 1'b0;
        end else begin
            abort_pulse <= (state == ST_REARMED) && start_seen;
            rearm_pulse <= (state == ST_BUSY) && cs_fall && !op_done;
            if (nxt == ST_SHIFT && state != ST_SHIFT) begin
                cnt   <= CW'(1);
                shreg <= '0;
            end else if (state == ST_SHIFT && bit_stb) begin
                cnt   <= cnt + CW'(1);
                shreg <= {shreg[PAY_BITS-3:0], din_s};
            end
            if (byte_done)
                pd_pend <= (byte_word[4:3] == OP_PDOWN);
        end
    end

endmodule

// File: rtl/ctrl_rx_regs.sv
module ctrl_rx_regs
    import ctrl_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_done,
    input  logic [PAY_BITS-1:0]  byte_word,
    output logic                 byte_valid,
    output logic                 cfg_unipolar,
    output logic                 cfg_int_clk,
    output logic [1:0]           op_mode,
    output logic                 acq_long,
    output logic [PORT_BITS-1:0] port_out
);

    cmd_t cmd;
    assign cmd = cmd_t'(byte_word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid   <= 1'b0;
            cfg_unipolar <= 1'b0;
            cfg_int_clk  <= 1'b1;
            op_mode      <= OP_SHORT;
            acq_long     <= 1'b0;
            port_out     <= '0;
        end else begin
            byte_valid <= byte_done;
            if (byte_done) begin
                cfg_unipolar <= cmd.unipolar;
                cfg_int_clk  <= cmd.int_clk;
                op_mode      <= cmd.op;
                port_out     <= cmd.port;
                if (cmd.op == OP_SHORT)     acq_long <= 1'b0;
                else if (cmd.op == OP_LONG) acq_long <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ctrl_byte_rx.sv
module ctrl_byte_rx
    import ctrl_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shdn_n,
    input  logic       sclk_pin,
    input  logic       csn_pin,
    input  logic       din_pin,
    input  logic       op_done,
    output logic       byte_valid,
    output logic       cfg_unipolar,
    output logic       cfg_int_clk,
    output logic [1:0] op_mode,
    output logic       acq_long,
    output logic [2:0] port_out,
    output logic       abort_pulse,
    output logic       rearm_pulse,
    output logic       powered_down
);

    logic [2:0]          pins_s;
    logic                sclk_s, csn_s, din_s;
    logic                sclk_d, csn_d;
    logic                bit_stb, cs_fall;
    logic                byte_done;
    logic [PAY_BITS-1:0] byte_word;
    logic                sleep_st;

    ctrl_rx_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b010)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sclk_pin, csn_pin, din_pin}),
        .sync_out (pins_s)
    );

    assign {sclk_s, csn_s, din_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    assign bit_stb = shdn_n && !csn_s && sclk_s && !sclk_d;
    assign cs_fall = shdn_n && !csn_s && csn_d;

    ctrl_rx_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .din_s       (din_s),
        .cs_fall     (cs_fall),
        .op_done     (op_done),
        .byte_done   (byte_done),
        .byte_word   (byte_word),
        .abort_pulse (abort_pulse),
        .rearm_pulse (rearm_pulse),
        .sleep_st    (sleep_st)
    );

    ctrl_rx_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_done    (byte_done),
        .byte_word    (byte_word),
        .byte_valid   (byte_valid),
        .cfg_unipolar (cfg_unipolar),
        .cfg_int_clk  (cfg_int_clk),
        .op_mode      (op_mode),
        .acq_long     (acq_long),
        .port_out     (port_out)
    );

    assign powered_down = sleep_st || !shdn_n;

endmodule

// File: rtl/ctrl_byte_rx_chk.sv
module ctrl_byte_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       shdn_n,
    input logic       byte_valid,
    input logic       abort_pulse,
    input logic       rearm_pulse,
    input logic       powered_down,
    input logic       acq_long,
    input logic [1:0] op_mode,
    input logic [2:0] port_out
);

    // R4
    port_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_out) |-> byte_valid);

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R3
    mode_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(op_mode) |-> byte_valid);

    // R3
    acq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && (op_mode == 2'b01 || op_mode == 2'b10)) |-> $stable(acq_long));

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({abort_pulse, rearm_pulse, byte_valid}));

    // R7
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    // R9
    shdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> ($stable(port_out) && !byte_valid));

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (powered_down && shdn_n) |-> !abort_pulse);

endmodule

bind ctrl_byte_rx ctrl_byte_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shdn_n       (shdn_n),
    .byte_valid   (byte_valid),
    .abort_pulse  (abort_pulse),
    .rearm_pulse  (rearm_pulse),
    .powered_down (powered_down),
    .acq_long     (acq_long),
    .op_mode      (op_mode),
    .port_out     (port_out)
);

// File: tb/ctrl_byte_rx_bench.sv
`timescale 1ns/1ps
module ctrl_byte_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shdn_n = 1'b1;
    logic       sclk_pin = 1'b0;
    logic       csn_pin = 1'b1;
    logic       din_pin = 1'b0;
    logic       op_done = 1'b0;
    logic       byte_valid, cfg_unipolar, cfg_int_clk, acq_long;
    logic [1:0] op_mode;
    logic [2:0] port_out;
    logic       abort_pulse, rearm_pulse, powered_down;

    int n_checks = 0;
    int n_fail   = 0;
    int n_bv = 0, n_abort = 0, n_rearm = 0;

    always #10 clk = ~clk;

    ctrl_byte_rx u_ctrl_byte_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .shdn_n       (shdn_n),
        .sclk_pin     (sclk_pin),
        .csn_pin      (csn_pin),
        .din_pin      (din_pin),
        .op_done      (op_done),
        .byte_valid   (byte_valid),
        .cfg_unipolar (cfg_unipolar),
        .cfg_int_clk  (cfg_int_clk),
        .op_mode      (op_mode),
        .acq_long     (acq_long),
        .port_out     (port_out),
        .abort_pulse  (abort_pulse),
        .rearm_pulse  (rearm_pulse),
        .powered_down (powered_down)
    );

    always @(posedge clk) begin
        if (rst_n && byte_valid)  n_bv++;
        if (rst_n && abort_pulse) n_abort++;
        if (rst_n && rearm_pulse) n_rearm++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        din_pin = b;
        wait_clk(4);
        sclk_pin = 1'b1;
        wait_clk(4);
        sclk_pin = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        wait_clk(4);
    endtask

    task automatic pulse_done();
        op_done = 1'b1;
        wait_clk(1);
        op_done = 1'b0;
        wait_clk(3);
    endtask

    task automatic t_reset();
        check("R8 port", port_out, 0);
        check("R8 unipolar", cfg_unipolar, 0);
        check("R8 int_clk", cfg_int_clk, 1);
        check("R8 op_mode", op_mode, 0);
        check("R8 acq_long", acq_long, 0);
        check("R8 powered_down", powered_down, 0);
    endtask

    task automatic t_leading_zeros();
        int bv0 = n_bv;
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        check("R1 zeros ignored", n_bv - bv0, 0);
        send_byte(8'hDD);
        check("R1 byte framed", n_bv - bv0, 1);
        check("R2 unipolar", cfg_unipolar, 1);
        check("R2 int_clk", cfg_int_clk, 0);
        check("R3 op_mode long", op_mode, 3);
        check("R3 acq_long", acq_long, 1);
        check("R4 port", port_out, 5);
    endtask

    task automatic t_busy_ignore();
        int bv0 = n_bv;
        send_byte(8'h87);
        check("R6 busy no byte", n_bv - bv0, 0);
        check("R6 port held", port_out, 5);
        pulse_done();
    endtask

    task automatic t_cs_high();
        int bv0 = n_bv;
        csn_pin = 1'b1;
        wait_clk(6);
        send_byte(8'hC2);
        check("R5 deselected no byte", n_bv - bv0, 0);
        check("R5 port held", port_out, 5);
        csn_pin = 1'b0;
        wait_clk(6);
        send_byte(8'h81);
        check("R2 bipolar", cfg_unipolar, 0);
        check("R3 op_mode short", op_mode, 0);
        check("R3 acq_long short", acq_long, 0);
        check("R4 port 001", port_out, 1);
    endtask

    task automatic t_abort();
        int r0 = n_rearm;
        int a0 = n_abort;
        int bv0 = n_bv;
        csn_pin = 1'b1;
        wait_clk(6);
        csn_pin = 1'b0;
        wait_clk(6);
        check("R7 rearm", n_rearm - r0, 1);
        send_byte(8'hA6);
        check("R7 abort", n_abort - a0, 1);
        check("R7 new byte", n_bv - bv0, 1);
        check("R7 port", port_out, 6);
        check("R7 int_clk", cfg_int_clk, 1);
        pulse_done();
    endtask

    task automatic t_powerdown();
        int a0;
        send_byte(8'h9A);
        check("R3 acq_long after 11", acq_long, 1);
        pulse_done();
        send_byte(8'h92);
        check("R10 op_mode pdown", op_mode, 2);
        check("R10 acq_long kept", acq_long, 1);
        check("R10 awake before done", powered_down, 0);
        pulse_done();
        check("R10 sleep", powered_down, 1);
        check("R10 port held", port_out, 2);
        a0 = n_abort;
        send_byte(8'h83);
        check("R10 no abort on wake", n_abort - a0, 0);
        check("R10 awake", powered_down, 0);
        check("R10 port new", port_out, 3);
        pulse_done();
    endtask

    task automatic t_shutdown();
        int bv0 = n_bv;
        shdn_n = 1'b0;
        wait_clk(2);
        send_byte(8'hFF);
        check("R9 no byte", n_bv - bv0, 0);
        check("R9 port held", port_out, 3);
        check("R9 mode held", op_mode, 0);
        shdn_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic t_reset_again();
        rst_n = 1'b0;
        wait_clk(3);
        t_reset();
        rst_n = 1'b1;
        wait_clk(3);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clk(3);
        t_reset();
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        csn_pin = 1'b0;
        wait_clk(6);
        t_leading_zeros();
        t_busy_ignore();
        t_cs_high();
        t_abort();
        t_powerdown();
        t_shutdown();
        t_reset_again();
        finish_run();
    end

endmodule